// File: doc/BRIEF.md
# Staggered Half-Word Integer Adder

This unit performs 32-bit add, subtract and bitwise logic on a clock that runs at twice the core rate. The sum is not produced in one piece: the low 16 bits come out after the first fast cycle, the high 16 bits after the second, and the condition flags after the third. The high half uses the carry that the low half registered one cycle earlier. As a result, each fast cycle only has to fit one 16-bit adder and the multiplexers that feed it.

Each half of a result can be forwarded to the operation issued immediately after it, at the moment that half is ready. A chain of dependent operations can therefore issue on every fast cycle with no bubbles. The low half appears at its own output one cycle after issue. This lets a data-cache access that uses the result as an address begin before the high half exists. Shifts, multiplication and branch resolution are handled elsewhere.

Top module: `stag_alu`

## Requirements
- R1: An operation presented with `valid_i` high at a rising edge shows bits 15:0 of its result on `lo_o`, with `lo_vld_o` high, one cycle after that edge.
- R2: Bits 31:16 of the result appear on `hi_o` two cycles after issue, with `hi_vld_o` high, and `res_o` holds the full 32-bit result in that same cycle. The high half includes the carry out of that same operation's low half.
- R3: `flags_o` is valid three cycles after issue, with `flag_vld_o` high. Its encoding is {negative, zero, carry, overflow} from bit 3 down to bit 0. Negative is result bit 31, and zero is set when all 32 result bits are 0.
- R4: `op_i` codes are 0 add, 1 subtract (a minus b), 2 AND, 3 OR, 4 XOR.
- R5: When `byp_a_i` is high, operand A is replaced by the result of the operation issued in the previous cycle, half by half.
- R6: When `byp_b_i` is high, operand B is replaced in the same way by the previous cycle's result.
- R7: The carry flag is the carry out of bit 31 of a+b for add, and of a+~b+1 for subtract, so 1 means no borrow. For logic operations the carry flag is 0.
- R8: The overflow flag is signed two's-complement overflow for add and subtract, and 0 for logic operations.
- R9: While `rst_ni` is low, and in the first cycle after it is released, all three valid outputs are low.
- R10: Operations may issue on every cycle, including chains where every operation bypasses both operands, and each is completed correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast clock (twice the core rate) |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Issue an operation this cycle |
| op_i | input | 3 | Operation code |
| a_i | input | 32 | Operand A |
| b_i | input | 32 | Operand B |
| byp_a_i | input | 1 | Take A from the previous result |
| byp_b_i | input | 1 | Take B from the previous result |
| lo_vld_o | output | 1 | Low half valid |
| lo_o | output | 16 | Low result half, early address bits |
| hi_vld_o | output | 1 | High half valid |
| hi_o | output | 16 | High result half |
| res_o | output | 32 | Full result, aligned with hi_o |
| flag_vld_o | output | 1 | Flags valid |
| flags_o | output | 4 | {N, Z, C, V} |

## Verification
In any single cycle of a back-to-back stream, the unit does two things at once. It computes the low half of operation N+1 from the low half forwarded by operation N, and it computes the high half of operation N using N's own registered carry. The bench provokes this with long chains where every operation issues on consecutive cycles and both bypass selects are set pseudo-randomly. Operands are chosen so that carries cross the 16-bit boundary. Every result and flag set is compared with a plain 32-bit computation made in the bench, which resolves each bypassed operand from the bench's own previous result.

// File: rtl/stag_alu_pkg.sv
package stag_alu_pkg;
  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_AND = 3'd2,
    OP_OR  = 3'd3,
    OP_XOR = 3'd4
  } alu_op_e;

  localparam int unsigned FLAG_W = 4;
endpackage

// File: rtl/stag_half_slice.sv
module stag_half_slice
  import stag_alu_pkg::*;
#(
  parameter int unsigned HW = 16
) (
  input  alu_op_e         op_i,
  input  logic [HW-1:0]   a_i,
  input  logic [HW-1:0]   b_i,
  input  logic            cin_i,
  output logic [HW-1:0]   res_o,
  output logic            cout_o,
  output logic            ovf_o
);
  logic [HW-1:0] b_x;
  logic [HW:0]   sum;
  logic          arith;

  always_comb begin
    arith  = (op_i == OP_ADD) || (op_i == OP_SUB);
    b_x    = (op_i == OP_SUB) ? ~b_i : b_i;
    sum    = {1'b0, a_i} + {1'b0, b_x} + {{HW{1'b0}}, cin_i};
    case (op_i)
      OP_ADD, OP_SUB: res_o = sum[HW-1:0];
      OP_AND:         res_o = a_i & b_i;
      OP_OR:          res_o = a_i | b_i;
      OP_XOR:         res_o = a_i ^ b_i;
      default:        res_o = '0;
    endcase
    cout_o = arith & sum[HW];
    ovf_o  = arith & (a_i[HW-1] == b_x[HW-1]) & (sum[HW-1] != a_i[HW-1]);
  end
endmodule

// File: rtl/stag_flag_gen.sv
module stag_flag_gen
  import stag_alu_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0]      res_i,
  input  logic              cout_i,
  input  logic              ovf_i,
  output logic [FLAG_W-1:0] flags_o
);
  always_comb flags_o = {res_i[W-1], (res_i == '0), cout_i, ovf_i};
endmodule

// File: rtl/stag_alu.sv
module stag_alu
  import stag_alu_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  valid_i,
  input  logic [2:0]            op_i,
  input  logic [W-1:0]          a_i,
  input  logic [W-1:0]          b_i,
  input  logic                  byp_a_i,
  input  logic                  byp_b_i,
  output logic                  lo_vld_o,
  output logic [W/2-1:0]        lo_o,
  output logic                  hi_vld_o,
  output logic [W/2-1:0]        hi_o,
  output logic [W-1:0]          res_o,
  output logic                  flag_vld_o,
  output logic [FLAG_W-1:0]     flags_o
);
  localparam int unsigned HW = W / 2;

  alu_op_e op_in;
  assign op_in = alu_op_e'(op_i);

  // stage 1: low half
  logic          s1_vld, s1_byp_a, s1_byp_b, c_lo_q;
  alu_op_e       s1_op;
  logic [HW-1:0] s1_ahi, s1_bhi, lo_q;
  // stage 2: high half
  logic          s2_vld, co_q, ov_q;
  logic [HW-1:0] hi_q, lo_d;
  // stage 3: flags
  logic              s3_vld;
  logic [FLAG_W-1:0] flags_q;

  logic [HW-1:0] lo_a, lo_b, lo_res, hi_a, hi_b, hi_res;
  logic          lo_co, lo_ov, hi_co, hi_ov;
  logic [FLAG_W-1:0] flags_d;

  // forwarding muxes: each half takes the previous op's same half
  assign lo_a = byp_a_i  ? lo_q : a_i[HW-1:0];
  assign lo_b = byp_b_i  ? lo_q : b_i[HW-1:0];
  assign hi_a = s1_byp_a ? hi_q : s1_ahi;
  assign hi_b = s1_byp_b ? hi_q : s1_bhi;

  stag_half_slice #(.HW(HW)) u_lo (
    .op_i(op_in), .a_i(lo_a), .b_i(lo_b), .cin_i(op_in == OP_SUB),
    .res_o(lo_res), .cout_o(lo_co), .ovf_o(lo_ov)
  );

  stag_half_slice #(.HW(HW)) u_hi (
    .op_i(s1_op), .a_i(hi_a), .b_i(hi_b), .cin_i(c_lo_q),
    .res_o(hi_res), .cout_o(hi_co), .ovf_o(hi_ov)
  );

  stag_flag_gen #(.W(W)) u_flags (
    .res_i({hi_q, lo_d}), .cout_i(co_q), .ovf_i(ov_q), .flags_o(flags_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_vld   <= 1'b0;
      s1_op    <= OP_ADD;
      s1_ahi   <= '0;
      s1_bhi   <= '0;
      s1_byp_a <= 1'b0;
      s1_byp_b <= 1'b0;
      lo_q     <= '0;
      c_lo_q   <= 1'b0;
    end else begin
      s1_vld   <= valid_i;
      s1_op    <= op_in;
      s1_ahi   <= a_i[W-1:HW];
      s1_bhi   <= b_i[W-1:HW];
      s1_byp_a <= byp_a_i;
      s1_byp_b <= byp_b_i;
      lo_q     <= lo_res;
      c_lo_q   <= lo_co;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s2_vld <= 1'b0;
      hi_q   <= '0;
      lo_d   <= '0;
      co_q   <= 1'b0;
      ov_q   <= 1'b0;
    end else begin
      s2_vld <= s1_vld;
      hi_q   <= hi_res;
      lo_d   <= lo_q;
      co_q   <= hi_co;
      ov_q   <= hi_ov;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s3_vld  <= 1'b0;
      flags_q <= '0;
    end else begin
      s3_vld  <= s2_vld;
      flags_q <= flags_d;
    end
  end

  assign lo_vld_o   = s1_vld;
  assign lo_o       = lo_q;
  assign hi_vld_o   = s2_vld;
  assign hi_o       = hi_q;
  assign res_o      = {hi_q, lo_d};
  assign flag_vld_o = s3_vld;
  assign flags_o    = flags_q;
endmodule

// File: rtl/stag_alu_chk.sv
module stag_alu_chk #(
  parameter int unsigned W = 32
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           valid_i,
  input logic           lo_vld_o,
  input logic           hi_vld_o,
  input logic [W/2-1:0] hi_o,
  input logic [W-1:0]   res_o,
  input logic           flag_vld_o,
  input logic [3:0]     flags_o
);
  a_r1_lo_after_issue: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> lo_vld_o);

  a_r2_hi_after_lo: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lo_vld_o |=> hi_vld_o);

  a_r3_flags_after_hi: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hi_vld_o |=> flag_vld_o);

  a_r3_zero_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hi_vld_o |=> (flags_o[2] == ($past(res_o) == '0)));

  a_r3_neg_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hi_vld_o |=> (flags_o[3] == $past(hi_o[W/2-1])));

  a_r9_no_spurious_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hi_vld_o |=> !flag_vld_o);
endmodule

bind stag_alu stag_alu_chk #(.W(W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .lo_vld_o(lo_vld_o),
  .hi_vld_o(hi_vld_o), .hi_o(hi_o), .res_o(res_o),
  .flag_vld_o(flag_vld_o), .flags_o(flags_o)
);

// File: tb/sim_stag_alu.sv
module sim_stag_alu;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [2:0]  op_i = 3'd0;
  logic [31:0] a_i = '0, b_i = '0;
  logic        byp_a_i = 1'b0, byp_b_i = 1'b0;
  logic        lo_vld_o, hi_vld_o, flag_vld_o;
  logic [15:0] lo_o, hi_o;
  logic [31:0] res_o;
  logic [3:0]  flags_o;

  always #5 clk_i = ~clk_i;

  stag_alu u0 (.*);

  int n_chk = 0, n_err = 0;
  int n_iss = 0, n_lo = 0, n_hi = 0, n_fl = 0;
  logic [31:0] exp_r [2048];
  logic [3:0]  exp_f [2048];
  logic [2:0]  exp_o [2048];
  logic [1:0]  exp_b [2048];
  logic [31:0] prev_r = '0;

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic ref_op(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b,
                        output logic [31:0] r, output logic [3:0] f);
    logic [32:0] s;
    logic c, v;
    c = 1'b0; v = 1'b0; s = '0;
    case (op)
      3'd0: begin s = {1'b0, a} + {1'b0, b}; r = s[31:0]; c = s[32];
                  v = (a[31] == b[31]) && (r[31] != a[31]); end
      3'd1: begin s = {1'b0, a} + {1'b0, ~b} + 33'd1; r = s[31:0]; c = s[32];
                  v = (a[31] != b[31]) && (r[31] != a[31]); end
      3'd2: r = a & b;
      3'd3: r = a | b;
      default: r = a ^ b;
    endcase
    f = {r[31], r == 32'd0, c, v};
  endtask

  task automatic issue(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic ba, input logic bb);
    logic [31:0] ae, be, r;
    logic [3:0] f;
    @(negedge clk_i);
    ae = ba ? prev_r : a;
    be = bb ? prev_r : b;
    ref_op(op, ae, be, r, f);
    valid_i = 1'b1; op_i = op; a_i = a; b_i = b; byp_a_i = ba; byp_b_i = bb;
    exp_r[n_iss] = r; exp_f[n_iss] = f; exp_o[n_iss] = op; exp_b[n_iss] = {ba, bb};
    prev_r = r;
    n_iss++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      valid_i = 1'b0; byp_a_i = 1'b0; byp_b_i = 1'b0;
    end
  endtask

  // output monitor, sampling away from the active edge
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (lo_vld_o) begin
        chk(lo_o == exp_r[n_lo][15:0], "R1 low half", {16'd0, lo_o}, {16'd0, exp_r[n_lo][15:0]});
        n_lo++;
      end
      if (hi_vld_o) begin
        if (exp_b[n_hi] != 2'b00)
          chk(res_o == exp_r[n_hi], "R5 R6 R10 bypassed result", res_o, exp_r[n_hi]);
        else if (exp_o[n_hi] >= 3'd2)
          chk(res_o == exp_r[n_hi], "R4 logic result", res_o, exp_r[n_hi]);
        else
          chk(res_o == exp_r[n_hi], "R2 arithmetic result", res_o, exp_r[n_hi]);
        chk(hi_o == exp_r[n_hi][31:16], "R2 high half", {16'd0, hi_o}, {16'd0, exp_r[n_hi][31:16]});
        n_hi++;
      end
      if (flag_vld_o) begin
        chk(flags_o[3:2] == exp_f[n_fl][3:2], "R3 N/Z flags", {28'd0, flags_o}, {28'd0, exp_f[n_fl]});
        chk(flags_o[1] == exp_f[n_fl][1], "R7 carry flag", {28'd0, flags_o}, {28'd0, exp_f[n_fl]});
        chk(flags_o[0] == exp_f[n_fl][0], "R8 overflow flag", {28'd0, flags_o}, {28'd0, exp_f[n_fl]});
        n_fl++;
      end
    end
  end

  logic [31:0] vals [9] = '{32'h0, 32'h1, 32'h0000_FFFF, 32'h0000_8000, 32'h7FFF_FFFF,
                            32'h8000_0000, 32'hFFFF_FFFF, 32'h0001_FFFF, 32'h1234_5678};
  bit done = 1'b0;

  initial begin
    logic [31:0] lf;
    // R9: reset state
    repeat (3) @(negedge clk_i);
    chk({lo_vld_o, hi_vld_o, flag_vld_o} == 3'b000, "R9 valids in reset",
        {29'd0, lo_vld_o, hi_vld_o, flag_vld_o}, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk({lo_vld_o, hi_vld_o, flag_vld_o} == 3'b000, "R9 valids after release",
        {29'd0, lo_vld_o, hi_vld_o, flag_vld_o}, 32'd0);

    // R4 R7 R8: corner operand sweep, all ops, back to back
    for (int op = 0; op < 5; op++)
      for (int i = 0; i < 9; i++)
        for (int j = 0; j < 9; j++)
          issue(3'(op), vals[i], vals[j], 1'b0, 1'b0);
    idle(2);

    // R2 R5: carry rippling across the half boundary through a bypass chain
    issue(3'd0, 32'h0000_FFFF, 32'h1, 1'b0, 1'b0);
    issue(3'd0, 32'h0, 32'h0000_FFFF, 1'b1, 1'b0);
    issue(3'd1, 32'h0, 32'h0001_0000, 1'b0, 1'b1);
    issue(3'd0, 32'h0, 32'h0, 1'b1, 1'b1);
    issue(3'd1, 32'h0, 32'h0, 1'b1, 1'b1);
    idle(1);

    // R10 R5 R6: long dependent chains with pseudo-random operands and selects
    lf = 32'hACE1_2345;
    issue(3'd0, lf, ~lf, 1'b0, 1'b0);
    for (int k = 0; k < 600; k++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      issue(3'(lf[7:0] % 5), (lf[3] ? 32'h0000_FFFF : lf), {lf[15:0], lf[31:16]},
            lf[9], lf[11]);
    end
    idle(6);
    chk(n_fl == n_iss, "R10 all operations completed", n_fl, n_iss);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk_i);
        n_chk++; n_err++;
        $display("FAIL watchdog actual=%0d expected=%0d", n_fl, n_iss);
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule